// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static RAM Controller

The block connects a single-clock internal request port to an external asynchronous static RAM. The RAM has 512K locations of one byte each. Every access moves one byte. The RAM is selected only when its active-low select pin is low and its active-high select pin is high. A read needs output-enable low and write-enable high. A write is controlled by the write-enable pin, and output-enable stays high for the whole write. Each strobe phase is held for a whole number of clock cycles. Each count is the ceiling of a nanosecond limit divided by the clock-period parameter, with a floor of one cycle. At the 10 ns default period, a read holds its strobes for 7 cycles and a write pulse lasts 6 cycles, followed by one hold cycle.

When no request is pending, the controller deselects the RAM so that it idles in standby. After a read, the RAM may keep driving the data pins for up to 30 ns. The controller therefore holds back a following write until that window has passed.

Requests use valid/ready. The requester raises `req_valid` and keeps `req_wr`, `req_addr` and `req_wdata` stable until it sees `req_ready` high at a clock edge. That edge is the acceptance edge, and the fields are captured there. `req_ready` stays low until the access is complete, which is the only back-pressure. Read data comes back as a single-cycle pulse on `rsp_valid` that cannot be stalled.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is held, the outputs are as follows: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Whenever `req_ready` is high, the RAM is in standby (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1 and the data bus is not driven.
- R3: A request is accepted at an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the access completes. Address, write flag and data are captured at acceptance, so later changes to the request inputs have no effect on that access.
- R4: A read accepted at edge a drives the select pins active, `mem_oe_n` low and `mem_we_n` high during the N_RD cycles that start at a, where N_RD = 7 by default.
- R5: A read's byte is sampled from `mem_dq_i` at the end of its last strobe cycle. It appears on `rsp_data` with `rsp_valid` high for exactly one cycle, which is also the cycle in which `req_ready` returns high.
- R6: During a write, `mem_we_n` is low for N_WL consecutive cycles (6 by default) with `mem_oe_n` high. `mem_dq_oe` is high with the captured byte on `mem_dq_o` through those cycles and through one more cycle with `mem_we_n` high and the RAM still selected. `req_ready` returns in the cycle after that.
- R7: `mem_addr` holds the captured address for every cycle in which the RAM is selected. Each selected period of a read or a write lasts at least 70 ns, which is 7 cycles by default.
- R8: Let r be the cycle in which the last read's response appears. A write accepted at edge a starts its strobe in whichever comes later: cycle a, or cycle r + N_HZ, where N_HZ = 3 by default. The data bus is never driven within the RAM's 30 ns output release window.
- R9: `mem_oe_n` is never low in a cycle where `mem_we_n` is low or `mem_dq_oe` is high.
- R10: N_RD is the larger of ceil(T_RC/T) and ceil(T_AA/T). N_WL is the largest of ceil(T_WP/T), ceil(T_CW/T), ceil(T_DS/T) and ceil(T_WC/T) − 1. N_HZ is ceil(T_HZ/T). Every count is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_data | output | 8 | Read byte |
| mem_addr | output | 19 | RAM address pins |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Byte read from the RAM data bus |

## Verification
The bench contains a RAM model that returns the bitwise inverse of the stored byte until the full access time has passed. A controller that samples a read one cycle early therefore returns wrong data. The model also rejects short write pulses, short data setup and short select windows, so a design that cuts a strobe short loses or corrupts bytes. Writes are placed zero, one and two cycles after a read's response. A design with too short a turnaround drives the bus while the model still holds it, and the model reports this as contention. Request fields are scrambled right after acceptance, so a design that does not capture them writes to the wrong place or writes the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WLOW,
    ST_WEND
  } ctl_state_t;

  // Ceiling of a time limit over the clock period, never below one cycle.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_state_t nxt_state,
  output logic       sel,
  output logic       oe_n,
  output logic       we_n,
  output logic       drive
);

  // Pins are registered from the next state so they switch on the same edge as the FSM.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      drive <= 1'b0;
    end else begin
      sel   <= (nxt_state == ST_READ) || (nxt_state == ST_WLOW) || (nxt_state == ST_WEND);
      oe_n  <= (nxt_state != ST_READ);
      we_n  <= (nxt_state != ST_WLOW);
      drive <= (nxt_state == ST_WLOW) || (nxt_state == ST_WEND);
    end
  end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_WP_NS = 55,
  parameter int unsigned T_CW_NS = 60,
  parameter int unsigned T_DS_NS = 30,
  parameter int unsigned T_HZ_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned N_RD = max2(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_AA_NS, CLK_NS));
  localparam int unsigned N_WC1 = (ns_to_cycles(T_WC_NS, CLK_NS) > 1) ? ns_to_cycles(T_WC_NS, CLK_NS) - 1 : 1;
  localparam int unsigned N_WL = max2(max2(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_CW_NS, CLK_NS)),
                                      max2(ns_to_cycles(T_DS_NS, CLK_NS), N_WC1));
  localparam int unsigned N_HZ = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned TW   = $clog2(max2(N_RD, N_WL) + 1);
  localparam int unsigned HW   = $clog2(N_HZ + 1);

  ctl_state_t        state_q, state_d;
  logic              main_load, main_done, hz_load, hz_done, capture;
  logic [TW-1:0]     main_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pin_sel;

  sram_phase_timer #(.CW(TW)) i_main_timer (
    .clk(clk), .rst_n(rst_n), .load(main_load), .load_val(main_val), .done(main_done)
  );

  sram_phase_timer #(.CW(HW)) i_hz_timer (
    .clk(clk), .rst_n(rst_n), .load(hz_load), .load_val(HW'(N_HZ - 1)), .done(hz_done)
  );

  always_comb begin
    state_d   = state_q;
    main_load = 1'b0;
    main_val  = '0;
    hz_load   = 1'b0;
    capture   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (!req_wr) begin
          state_d   = ST_READ;
          main_load = 1'b1;
          main_val  = TW'(N_RD - 1);
        end else if (hz_done) begin
          state_d   = ST_WLOW;
          main_load = 1'b1;
          main_val  = TW'(N_WL - 1);
        end else begin
          state_d   = ST_TURN;
        end
      end
      ST_TURN: if (hz_done) begin
        state_d   = ST_WLOW;
        main_load = 1'b1;
        main_val  = TW'(N_WL - 1);
      end
      ST_READ: if (main_done) begin
        state_d = ST_IDLE;
        capture = 1'b1;
        hz_load = 1'b1;
      end
      ST_WLOW: if (main_done) state_d = ST_WEND;
      ST_WEND: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= capture;
      if (capture) rsp_data <= mem_dq_i;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_pin_decode i_pins (
    .clk(clk), .rst_n(rst_n), .nxt_state(state_d),
    .sel(pin_sel), .oe_n(mem_oe_n), .we_n(mem_we_n), .drive(mem_dq_oe)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign mem_sel   = pin_sel;
  assign mem_sel_n = ~pin_sel;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;

  // Run-length counters used only by the properties below.
  localparam int unsigned OW = $clog2(N_HZ + 2);
  localparam int unsigned WW = $clog2(N_WL + 2);
  logic [OW-1:0] oe_hi_run;
  logic [WW-1:0] we_lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_run <= '1;
      we_lo_run <= '0;
    end else begin
      if (!mem_oe_n)          oe_hi_run <= '0;
      else if (oe_hi_run != '1) oe_hi_run <= oe_hi_run + 1'b1;
      if (!mem_we_n) begin
        if (we_lo_run != '1) we_lo_run <= we_lo_run + 1'b1;
      end else begin
        we_lo_run <= '0;
      end
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && !mem_dq_oe && mem_we_n)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!mem_oe_n)); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && $past(!mem_we_n)) |-> (we_lo_run >= WW'(N_WL))); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && $past(mem_sel)) |-> $stable(mem_addr)); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_run >= OW'(N_HZ))); // R8
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R9

endmodule

// File: tb/test_sram_byte_ctrl.sv
module test_sram_byte_ctrl;

  // Independent expectations from R10 at a 10 ns clock.
  localparam int RD_CYC = 7;  // max(ceil(70/10), ceil(70/10))
  localparam int WL_CYC = 6;  // max(ceil(55/10), ceil(60/10), ceil(30/10), 7-1)
  localparam int HZ_CYC = 3;  // ceil(30/10)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [18:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mdl_dq = '0;

  int checks = 0, fails = 0, cyc_no = 0;

  always #5 clk = ~clk;

  sram_byte_ctrl i_sram_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mdl_dq)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc_no);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0]  mem_m [int unsigned];
  int          rd_run = 0, drv_hold = 0, we_run = 0, ds_run = 0, sel_run = 0;
  bit          prev_wr = 0;
  logic [18:0] rd_addr = '0, w_addr = '0;
  logic [7:0]  w_data = '0;

  function automatic logic [7:0] mdl_get(logic [18:0] a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    bit sel, rd, wr;
    sel = !mem_sel_n && mem_sel;
    rd  = sel && !mem_oe_n && mem_we_n;
    wr  = sel && !mem_we_n;
    if (mem_dq_oe) chk(drv_hold == 0 && !rd, "R8", "bus contention with RAM output", drv_hold, 0);
    if (rd) begin
      rd_run   = (rd_run == 0 || mem_addr != rd_addr) ? 1 : rd_run + 1;
      rd_addr  = mem_addr;
      drv_hold = HZ_CYC;
      mdl_dq  <= (rd_run * 10 >= 70) ? mdl_get(mem_addr) : ~mdl_get(mem_addr);
    end else begin
      rd_run = 0;
      if (drv_hold > 0) drv_hold--;
      mdl_dq <= 8'($urandom);
    end
    if (wr) begin
      if (!prev_wr) begin we_run = 0; ds_run = 0; w_addr = mem_addr; end
      chk(mem_oe_n, "R9", "output enable low during write", mem_oe_n, 1);
      chk(mem_addr == w_addr, "R7", "address moved during write", mem_addr, w_addr);
      if (mem_dq_oe && we_run > 0 && mem_dq_o == w_data) ds_run++;
      else ds_run = mem_dq_oe ? 1 : 0;
      w_data = mem_dq_o;
      we_run++;
    end else if (prev_wr) begin
      chk(we_run * 10 >= 55, "R6", "write pulse ns", we_run * 10, 55);
      chk(ds_run * 10 >= 30, "R6", "data setup ns", ds_run * 10, 30);
      chk(we_run * 10 >= 60, "R7", "select before write end ns", we_run * 10, 60);
      mem_m[w_addr] = w_data;
    end
    prev_wr = wr;
    if (sel) sel_run++;
    else if (sel_run > 0) begin
      chk(sel_run * 10 >= 70, "R7", "selected period ns", sel_run * 10, 70);
      sel_run = 0;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [7:0]  ref_m [int unsigned];
  logic [7:0]  exp_q [$];
  bit          op_act = 0, op_wr = 0;
  int          op_a = 0, op_s = 0, last_rsp = -100;
  logic [18:0] op_addr = '0;
  logic [7:0]  op_data = '0;

  always @(negedge clk) if (rst_n) begin
    bit busy, ph, e_sel, e_oe_n, e_we_n, e_drv, e_rsp;
    cyc_no++;
    busy  = op_act && cyc_no >= op_a && cyc_no <= op_s + 6;
    ph    = op_act && cyc_no >= op_s && cyc_no <= op_s + 6;
    e_sel = ph;
    e_oe_n = !(ph && !op_wr);
    e_we_n = !(op_act && op_wr && cyc_no >= op_s && cyc_no <= op_s + WL_CYC - 1);
    e_drv  = ph && op_wr;
    e_rsp  = op_act && !op_wr && cyc_no == op_s + RD_CYC;
    chk(req_ready == !busy, "R3 R8", "req_ready", req_ready, !busy);
    chk(mem_sel == e_sel && mem_sel_n == !e_sel, "R2 R7", "select pins", mem_sel, e_sel);
    chk(mem_oe_n == e_oe_n, "R4 R10", "mem_oe_n", mem_oe_n, e_oe_n);
    chk(mem_we_n == e_we_n, "R6 R10", "mem_we_n", mem_we_n, e_we_n);
    chk(mem_dq_oe == e_drv, "R6", "mem_dq_oe", mem_dq_oe, e_drv);
    chk(!(mem_oe_n == 1'b0 && (mem_dq_oe || !mem_we_n)), "R9", "oe low with write", mem_oe_n, 1);
    chk(rsp_valid == e_rsp, "R5", "rsp_valid", rsp_valid, e_rsp);
    if (ph) chk(mem_addr == op_addr, "R7", "mem_addr", mem_addr, op_addr);
    if (e_drv) chk(mem_dq_o == op_data, "R6", "mem_dq_o", mem_dq_o, op_data);
    if (e_rsp) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      chk(rsp_data == e, "R5", "rsp_data", rsp_data, e);
      last_rsp = cyc_no;
    end
    if (op_act && cyc_no >= op_s + 7) op_act = 0;
    if (req_valid && req_ready) begin
      op_act  = 1;
      op_wr   = req_wr;
      op_addr = req_addr;
      op_data = req_wdata;
      op_a    = cyc_no + 1;
      op_s    = req_wr ? ((op_a > last_rsp + HZ_CYC) ? op_a : last_rsp + HZ_CYC) : op_a;
      if (req_wr) ref_m[req_addr] = req_wdata;
      else exp_q.push_back(ref_m.exists(req_addr) ? ref_m[req_addr] : 8'h00);
    end
    if (cyc_no >= 150000) begin
      chk(0, "watchdog", "run did not finish", cyc_no, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit wr, logic [18:0] a, logic [7:0] d);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;                       // R3: scramble fields after acceptance
    req_wr    = 1'($urandom);
    req_addr  = 19'($urandom);
    req_wdata = 8'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic drain();
    while (op_act || exp_q.size() > 0) begin @(posedge clk); #2; end
    idle(4);
  endtask

  logic [18:0] pool [8] = '{19'h00000, 19'h7FFFF, 19'h12345, 19'h00001,
                            19'h40000, 19'h3FFFF, 19'h0ABCD, 19'h55555};

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_sel_n && !mem_sel, "R1", "reset select", mem_sel, 0);
    chk(mem_oe_n && mem_we_n, "R1", "reset strobes", {mem_oe_n, mem_we_n}, 3);
    chk(!mem_dq_oe, "R1", "reset drive", mem_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1", "reset handshake", {req_ready, rsp_valid}, 2);
    @(posedge clk); #2; rst_n = 1'b1;
    idle(3);
    issue(1, 19'h12345, 8'hA5);
    issue(0, 19'h12345, 8'h00);             // R4 R5 basic read
    issue(0, 19'h7FFFF, 8'h00);             // unwritten location reads 0
    issue(1, 19'h00000, 8'h5A);             // R8 write right after read response
    issue(1, 19'h7FFFF, 8'hFF);
    issue(0, 19'h00000, 8'h00);
    idle(1);
    issue(1, 19'h00001, 8'h3C);             // R8 one idle cycle after read
    issue(0, 19'h7FFFF, 8'h00);
    idle(2);
    issue(1, 19'h00002, 8'hC3);             // R8 two idle cycles after read
    issue(0, 19'h00001, 8'h00);
    issue(0, 19'h00002, 8'h00);
    drain();
    for (int k = 0; k < 400; k++) begin
      bit wr;
      wr = 1'($urandom);
      issue(wr, pool[$urandom % 8], 8'($urandom));
      if (($urandom % 4) == 0) idle($urandom % 3);
    end
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule